// File: doc/BRIEF.md
# Burst Frame Sync and AMI Violation Monitor

This block watches the received side of several two-wire burst lines at once. Each line delivers one ternary symbol per strobe. A symbol is a mark of positive or negative polarity, or the neutral level. A shared boundary strobe marks the start of every burst frame. For each line the block decodes marks to ones and neutral symbols to zeros. It judges every completed frame by its framing bit and its length, and from those verdicts keeps a per-line synchronization flag with hysteresis.

At the same time, every line checks that its marks alternate in polarity within a frame. A break in that rule sets that line's bit in a shared error register. The register holds its bits until a host read strobe clears it. Clock recovery and payload descrambling are handled elsewhere.

Top module: `fsmon_top`

## Requirements
- R1: During and right after reset, `syncFlag`, `bitValid`, `bitOut` and `errReg` are all zero.
- R2: A frame is valid only when the first symbol received since its `frameStart` (that cycle included) is a mark and the frame holds exactly `FRAME_BITS` (37) symbols. The next `frameStart` judges the frame. The first `frameStart` after reset judges nothing.
- R3: A line's `syncFlag` rises on the `frameStart` edge that judges its 4th consecutive valid frame, and can be seen in the following cycle.
- R4: A synced line's `syncFlag` falls on the `frameStart` edge that judges its 4th consecutive invalid frame.
- R5: A frame of the opposite quality restarts the run count. Three valid frames, one invalid frame and three valid frames leave the flag low. Both counts saturate at their thresholds.
- R6: Symbols are encoded as 2'b01 positive mark, 2'b10 negative mark, and 2'b00 or 2'b11 neutral. A mark with the same polarity as the previous mark in the same frame is a violation, whatever neutral symbols lie between them. A violation on line n sets `errReg[n]` at that clock edge.
- R7: `errReg` bits stay set until `errRead` is sampled high. After that edge the register reads 00h.
- R8: A violation in the same cycle as `errRead` leaves its bit set after the clear.
- R9: Polarity history restarts at `frameStart`. A mark taken in the `frameStart` cycle never counts as a violation.
- R10: `bitValid` repeats `symValid` one cycle later. `bitOut` is 1 for a mark and 0 for a neutral symbol.
- R11: Lines are independent. The frames and symbols of one line do not change another line's flag or error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameStart | input | 1 | Shared frame boundary strobe |
| symValid | input | NUM_LINES | Per-line symbol strobe |
| symVal | input | 2*NUM_LINES | Per-line ternary symbol, line n at bits [2n+1:2n] |
| errRead | input | 1 | Error register read strobe (clear on read) |
| syncFlag | output | NUM_LINES | Per-line frame synchronization flag |
| bitOut | output | NUM_LINES | Decoded bit per line |
| bitValid | output | NUM_LINES | Decoded bit strobe per line |
| errReg | output | NUM_LINES | Sticky code-violation register, one bit per line |

## Verification
The bench uses the default parameters: eight lines, 37-symbol frames, and thresholds of four for both gaining and losing sync. Frames of exactly 37 symbols and frames one symbol short can then be told apart. The 4-frame acquisition and loss points fall within a few hundred cycles, and all eight error bits can be set in chosen patterns. The bench mixes line masks so that some lines gain sync while others stay unsynced. Near-threshold runs that are broken by a single frame of the other quality exercise the counter restart.

// File: rtl/fsmon_pkg.sv
package fsmon_pkg;
  localparam logic [1:0] SYM_ZERO = 2'b00;
  localparam logic [1:0] SYM_POS  = 2'b01;
  localparam logic [1:0] SYM_NEG  = 2'b10;

  // control -> datapath strobes
  typedef struct packed {
    logic restart;   // a new frame begins this cycle
    logic evaluate;  // the frame just ended is to be judged
  } frameStrobe_t;

  // datapath -> sync tracker verdict
  typedef struct packed {
    logic valid;
    logic good;
  } frameVerdict_t;
endpackage

// File: rtl/fsmon_frame_ctrl.sv
module fsmon_frame_ctrl
  import fsmon_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         frameStart,
  output frameStrobe_t strobe
);
  logic inFrame;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           inFrame <= 1'b0;
    else if (frameStart) inFrame <= 1'b1;
  end

  always_comb begin
    strobe.restart  = frameStart;
    strobe.evaluate = frameStart && inFrame;
  end
endmodule

// File: rtl/fsmon_line_dp.sv
module fsmon_line_dp
  import fsmon_pkg::*;
#(
  parameter int FRAME_BITS = 37
) (
  input  logic          clk,
  input  logic          rstN,
  input  frameStrobe_t  strobe,
  input  logic          symValid,
  input  logic [1:0]    symVal,
  output frameVerdict_t verdict,
  output logic          violation,
  output logic          bitOut,
  output logic          bitValid
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_CAP  = CNT_W'(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

  logic [CNT_W-1:0] symCnt, baseCnt;
  logic             framingOne;
  logic [1:0]       lastPol, histPol;
  logic             isMark;

  always_comb begin
    isMark    = symValid && (symVal == SYM_POS || symVal == SYM_NEG);
    baseCnt   = strobe.restart ? '0 : symCnt;
    histPol   = strobe.restart ? SYM_ZERO : lastPol;
    violation = isMark && (symVal == histPol);
    verdict.valid = strobe.evaluate;
    verdict.good  = framingOne && (symCnt == CNT_FULL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      symCnt     <= '0;
      framingOne <= 1'b0;
      lastPol    <= SYM_ZERO;
      bitOut     <= 1'b0;
      bitValid   <= 1'b0;
    end else begin
      if (symValid) begin
        if (baseCnt == '0) framingOne <= isMark;
        symCnt <= (baseCnt == CNT_CAP) ? CNT_CAP : baseCnt + 1'b1;
      end else if (strobe.restart) begin
        symCnt     <= '0;
        framingOne <= 1'b0;
      end
      if (isMark)              lastPol <= symVal;
      else if (strobe.restart) lastPol <= SYM_ZERO;
      bitOut   <= isMark;
      bitValid <= symValid;
    end
  end
endmodule

// File: rtl/fsmon_sync_track.sv
module fsmon_sync_track
  import fsmon_pkg::*;
#(
  parameter int SYNC_THRESH = 4,
  parameter int LOSS_THRESH = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  frameVerdict_t verdict,
  output logic          syncFlag
);
  localparam int GW = $clog2(SYNC_THRESH + 1);
  localparam int BW = $clog2(LOSS_THRESH + 1);
  localparam logic [GW-1:0] GOOD_MAX = GW'(SYNC_THRESH);
  localparam logic [BW-1:0] BAD_MAX  = BW'(LOSS_THRESH);

  logic [GW-1:0] goodCnt;
  logic [BW-1:0] badCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      goodCnt  <= '0;
      badCnt   <= '0;
      syncFlag <= 1'b0;
    end else if (verdict.valid) begin
      if (verdict.good) begin
        badCnt <= '0;
        if (goodCnt != GOOD_MAX) goodCnt <= goodCnt + 1'b1;
        if (goodCnt >= GOOD_MAX - 1'b1) syncFlag <= 1'b1;
      end else begin
        goodCnt <= '0;
        if (badCnt != BAD_MAX) badCnt <= badCnt + 1'b1;
        if (badCnt >= BAD_MAX - 1'b1) syncFlag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fsmon_err_reg.sv
module fsmon_err_reg #(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] violVec,
  input  logic                 errRead,
  output logic [NUM_LINES-1:0] errReg
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errReg <= '0;
    else       errReg <= (errRead ? '0 : errReg) | violVec;
  end
endmodule

// File: rtl/fsmon_top.sv
module fsmon_top
  import fsmon_pkg::*;
#(
  parameter int NUM_LINES   = 8,
  parameter int FRAME_BITS  = 37,
  parameter int SYNC_THRESH = 4,
  parameter int LOSS_THRESH = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   frameStart,
  input  logic [NUM_LINES-1:0]   symValid,
  input  logic [2*NUM_LINES-1:0] symVal,
  input  logic                   errRead,
  output logic [NUM_LINES-1:0]   syncFlag,
  output logic [NUM_LINES-1:0]   bitOut,
  output logic [NUM_LINES-1:0]   bitValid,
  output logic [NUM_LINES-1:0]   errReg
);
  frameStrobe_t         strobe;
  logic [NUM_LINES-1:0] violVec;

  fsmon_frame_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .strobe(strobe)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    frameVerdict_t verdict;

    fsmon_line_dp #(.FRAME_BITS(FRAME_BITS)) u_dp (
      .clk(clk), .rstN(rstN), .strobe(strobe),
      .symValid(symValid[g]), .symVal(symVal[2*g +: 2]),
      .verdict(verdict), .violation(violVec[g]),
      .bitOut(bitOut[g]), .bitValid(bitValid[g])
    );

    fsmon_sync_track #(.SYNC_THRESH(SYNC_THRESH), .LOSS_THRESH(LOSS_THRESH)) u_sync (
      .clk(clk), .rstN(rstN), .verdict(verdict), .syncFlag(syncFlag[g])
    );
  end

  fsmon_err_reg #(.NUM_LINES(NUM_LINES)) u_err (
    .clk(clk), .rstN(rstN), .violVec(violVec), .errRead(errRead), .errReg(errReg)
  );
endmodule

// File: rtl/fsmon_checker.sv
module fsmon_checker #(
  parameter int NUM_LINES = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 frameStart,
  input logic [NUM_LINES-1:0] symValid,
  input logic                 errRead,
  input logic [NUM_LINES-1:0] syncFlag,
  input logic [NUM_LINES-1:0] bitValid,
  input logic [NUM_LINES-1:0] errReg,
  input logic [NUM_LINES-1:0] violVec
);
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !errRead |=> ((errReg & $past(errReg)) == $past(errReg))); // R7

  AST_READ_KEEPS_NEW: assert property (@(posedge clk) disable iff (!rstN)
    errRead |=> (errReg == $past(violVec))); // R8

  AST_SYNC_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable(syncFlag)); // R3

  AST_FRAMING_NO_VIOL: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (violVec == '0)); // R9

  AST_DECODE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (bitValid == $past(symValid))); // R10

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_bit
    AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
      $rose(errReg[g]) |-> $past(violVec[g])); // R6
  end
endmodule

bind fsmon_top fsmon_checker #(.NUM_LINES(NUM_LINES)) u_fsmon_checker (
  .clk(clk), .rstN(rstN), .frameStart(frameStart), .symValid(symValid),
  .errRead(errRead), .syncFlag(syncFlag), .bitValid(bitValid),
  .errReg(errReg), .violVec(violVec)
);

// File: tb/test_fsmon_top.sv
module test_fsmon_top;
  localparam int NL = 8;
  localparam int FB = 37;
  localparam logic [1:0] ZR = 2'b00, PO = 2'b01, NE = 2'b10, RS = 2'b11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStart = 1'b0;
  logic [NL-1:0] symValid = '0;
  logic [2*NL-1:0] symVal = '0;
  logic errRead = 1'b0;
  logic [NL-1:0] syncFlag, bitOut, bitValid, errReg;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model of hysteresis and error register
  int goodM[NL], badM[NL];
  logic [NL-1:0] syncM, prevGood, expErr;
  bit havePrev;

  always #10 clk = ~clk;

  fsmon_top i_fsmon_top (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .symValid(symValid),
    .symVal(symVal), .errRead(errRead), .syncFlag(syncFlag),
    .bitOut(bitOut), .bitValid(bitValid), .errReg(errReg)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic fs, input logic rd, input logic [NL-1:0] vm,
                      input logic [2*NL-1:0] sy);
    @(negedge clk);
    frameStart = fs; errRead = rd; symValid = vm; symVal = sy;
    @(posedge clk);
    #2;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; frameStart = 0; errRead = 0; symValid = '0; symVal = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < NL; i++) begin goodM[i] = 0; badM[i] = 0; end
    syncM = '0; prevGood = '0; expErr = '0; havePrev = 0;
  endtask

  // one frame; fOne: lines whose framing symbol is a mark; vl: lines that get one violation
  task automatic runFrame(input logic [NL-1:0] fOne, input int len, input logic [NL-1:0] vl);
    for (int k = 0; k < len; k++) begin
      logic [2*NL-1:0] sy;
      logic [NL-1:0] expBit;
      for (int i = 0; i < NL; i++) begin
        logic [1:0] p;
        p = (k % 2 == 0) ? PO : NE;
        if (vl[i] && k >= 5) p = (p == PO) ? NE : PO;
        if (k == 0 && !fOne[i]) p = ZR;
        sy[2*i +: 2] = p;
        expBit[i] = (p != ZR);
      end
      tick(k == 0, 1'b0, '1, sy);
      if (k == 0 && havePrev) begin
        for (int i = 0; i < NL; i++) begin
          if (prevGood[i]) begin
            badM[i] = 0; goodM[i] = (goodM[i] < 4) ? goodM[i] + 1 : 4;
            if (goodM[i] >= 4) syncM[i] = 1'b1;
          end else begin
            goodM[i] = 0; badM[i] = (badM[i] < 4) ? badM[i] + 1 : 4;
            if (badM[i] >= 4) syncM[i] = 1'b0;
          end
        end
      end
      if (k == 0) chk(syncFlag === syncM, "R3 R4 R11 sync vs model", syncFlag, syncM);
      chk(bitOut === expBit && bitValid === '1, "R10 decode", bitOut, expBit);
    end
    havePrev = 1;
    prevGood = (len == FB) ? fOne : '0;
    if (len > 5) expErr = expErr | vl;
    chk(errReg === expErr, "R6 error bits after frame", errReg, expErr);
  endtask

  task automatic testReset();
    doReset();
    #2;
    chk(syncFlag === '0, "R1 sync after reset", syncFlag, 0);
    chk(errReg === '0 && bitValid === '0 && bitOut === '0, "R1 err/bit after reset", errReg, 0);
  endtask

  task automatic testAcquire();
    doReset();
    for (int f = 0; f < 4; f++) runFrame(8'hF0, FB, '0);
    chk(syncFlag === '0, "R3 no sync after three verdicts", syncFlag, 0);
    runFrame(8'hF0, FB, '0);
    chk(syncFlag === 8'hF0, "R3 R11 sync after fourth verdict", syncFlag, 8'hF0);
    chk(errReg === '0, "R9 no violation across frame boundary", errReg, 0);
  endtask

  task automatic testRestart();
    doReset();
    for (int f = 0; f < 3; f++) runFrame('1, FB, '0);
    runFrame('1, FB - 1, '0);              // R2 short frame is invalid
    for (int f = 0; f < 3; f++) runFrame('1, FB, '0);
    runFrame('1, FB, '0);
    chk(syncFlag === '0, "R5 R2 run restarted by short frame", syncFlag, 0);
    runFrame('1, FB, '0);
    chk(syncFlag === '1, "R5 sync after four fresh valid frames", syncFlag, 8'hFF);
  endtask

  task automatic testLoss();
    // continues from synced state of testRestart
    for (int f = 0; f < 3; f++) runFrame(8'h0F, FB, '0);
    runFrame(8'h0F, FB, '0);
    chk(syncFlag === '1, "R4 still synced after three invalid", syncFlag, 8'hFF);
    runFrame(8'h0F, FB, '0);
    chk(syncFlag === 8'h0F, "R4 R11 sync lost after four invalid", syncFlag, 8'h0F);
  endtask

  task automatic testViolations();
    doReset();
    runFrame('1, FB, 8'h05);
    chk(errReg === 8'h05, "R6 violation bits", errReg, 8'h05);
    runFrame('1, FB, 8'h80);
    chk(errReg === 8'h85, "R7 bits accumulate", errReg, 8'h85);
    tick(1'b0, 1'b1, '0, '0);
    chk(errReg === '0, "R7 clear on read", errReg, 0);
    tick(1'b0, 1'b0, '0, '0);
    chk(errReg === '0, "R7 stays clear", errReg, 0);
  endtask

  task automatic testManual();
    doReset();
    // marks separated by neutral symbols: pos, zero, reserved, pos -> violation on line 0
    tick(1'b1, 1'b0, 8'h01, {14'b0, PO});
    tick(1'b0, 1'b0, 8'h01, {14'b0, ZR});
    chk(errReg === '0, "R6 no violation yet", errReg, 0);
    tick(1'b0, 1'b0, 8'h03, {12'b0, RS, RS});
    chk(bitOut[1:0] === 2'b00 && bitValid[1:0] === 2'b11, "R10 reserved code is neutral",
        bitOut, 0);
    tick(1'b0, 1'b0, 8'h01, {14'b0, PO});
    chk(errReg === 8'h01, "R6 violation across neutral symbols", errReg, 8'h01);
    // read and new violation on line 3 in the same cycle
    tick(1'b0, 1'b0, 8'h08, {8'b0, NE, 6'b0});
    tick(1'b0, 1'b1, 8'h08, {8'b0, NE, 6'b0});
    chk(errReg === 8'h08, "R8 violation survives read", errReg, 8'h08);
    tick(1'b0, 1'b1, '0, '0);
    chk(errReg === '0, "R7 cleared", errReg, 0);
    // same polarity across a frame boundary on line 2 is not a violation
    tick(1'b0, 1'b0, 8'h04, {10'b0, PO, 4'b0});
    tick(1'b1, 1'b0, 8'h04, {10'b0, PO, 4'b0});
    chk(errReg === '0, "R9 history restarts at frameStart", errReg, 0);
    tick(1'b0, 1'b0, 8'h04, {10'b0, PO, 4'b0});
    chk(errReg === 8'h04, "R9 history within new frame", errReg, 8'h04);
    tick(1'b0, 1'b0, '0, '0);
    chk(bitValid === '0, "R10 strobe follows symValid", bitValid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    testReset();
    testAcquire();
    testRestart();
    testLoss();
    testViolations();
    testManual();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule